// File: doc/BRIEF.md
# Complement-Mirrored Variable Store

This block holds a small set of critical variables in a way that exposes corruption, whether the cause is a hardware upset or a stray software write. Every variable has two copies in two separate banks. Bank A keeps the true value and bank B keeps its bitwise inverse. The banks sit in different halves of one physical address space: index `i` maps to address `{0,i}` in bank A and to address `{1,i}` in bank B. Each bank holds exactly one copy of each variable, so no two copies of the same variable are ever adjacent.

A read fetches both copies and checks that they are exact complements. It returns the true copy together with a corruption flag. The flag feeds a sticky error bit and a one-cycle recovery request, which an outside controller answers by rebooting or restoring defaults. Two test ports are provided. The first XORs a mask into one word of one bank without using the write path. The second forces every word of both banks to a single constant, which models a stuck memory fill.

Top module: `mirror_store`

## Requirements
- R1: A write on `wr_en` stores `wr_data` in bank A and `~wr_data` in bank B. A read on `rd_en` gives `rd_valid` high in the next cycle only. In that cycle `rd_data` equals the last value written to `rd_idx`, and `rd_corrupt` is 0.
- R2: After reset, every index reads as 0 with `rd_corrupt` = 0, and `rd_valid`, `err_sticky` and `recover_req` are all 0.
- R3: A mask with a single bit set, injected into either bank (`inj_bank` 0 = bank A, 1 = bank B) at one index, makes the next read of that index return `rd_corrupt` = 1.
- R4: A stuck fill loads the same value into every word of both banks. After a fill of 0x0000, 0xFFFF or any other constant, every index reads with `rd_corrupt` = 1.
- R5: If the same bit position is flipped in both copies of one index, the corruption is not detected: `rd_corrupt` = 0 and `rd_data` is the written value with that bit inverted.
- R6: A read that returns `rd_corrupt` = 1 sets `err_sticky` in the same cycle. `err_sticky` stays set until `err_clr`. If a corrupt read result and `err_clr` fall in the same cycle, the set wins.
- R7: `recover_req` is a one-cycle pulse that coincides with a corrupt read result while `err_sticky` was clear. A further corrupt read while `err_sticky` is already set gives no pulse.
- R8: Writing an index again after it was corrupted restores clean reads of that index.
- R9: An injection changes only the addressed bank and index. All other variables keep reading clean.
- R10: A read and a write to the same index in the same cycle return the value held before that write. The new value is seen by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Variable index to write |
| wr_data | input | DATA_W | Value to write |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | IDX_W | Variable index to read |
| rd_valid | output | 1 | Read result valid (one cycle after `rd_en`) |
| rd_data | output | DATA_W | True copy of the variable that was read |
| rd_corrupt | output | 1 | The two copies were not exact complements |
| err_sticky | output | 1 | Latched corruption indication |
| err_clr | input | 1 | Clears `err_sticky` |
| recover_req | output | 1 | One-cycle request to the recovery controller |
| inj_en | input | 1 | Bit-flip injection strobe |
| inj_bank | input | 1 | Injection target: 0 = bank A, 1 = bank B |
| inj_idx | input | IDX_W | Injection index |
| inj_mask | input | DATA_W | Mask XORed into the target word |
| fill_en | input | 1 | Stuck-fill strobe for both banks |
| fill_val | input | DATA_W | Constant loaded into every word of both banks |

## Verification
Some properties are checked on every cycle:
- the read handshake timing;
- that `rd_corrupt` only appears on a valid result;
- that `err_sticky` never rises without a corrupt result, and holds until it is cleared;
- that `recover_req` is a single pulse caused by a first detection.

Other behaviour only the bench scenarios can show: the value mapping between the banks, detection of single flips in each bank, detection of stuck fills at both constant extremes and in between, the undetected same-position double flip, the isolation of injections, and read-before-write ordering.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
  typedef enum logic {
    BANK_TRUE = 1'b0,
    BANK_INV  = 1'b1
  } bank_sel_e;

  // Two copies agree only when every bit position differs.
  function automatic logic copies_match(input logic [63:0] a, input logic [63:0] b,
                                        input int unsigned width);
    logic ok;
    ok = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < width && a[i] == b[i]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/mirror_rst_sync.sv
module mirror_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/mirror_bank.sv
module mirror_bank #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_VARS = 8,
  parameter int unsigned REGION   = 0,
  parameter bit          INVERT   = 1'b0,
  localparam int unsigned IDX_W   = $clog2(NUM_VARS),
  localparam int unsigned PA_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              inj_en,
  input  logic [PA_W-1:0]   inj_addr,
  input  logic [DATA_W-1:0] inj_mask,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_word,
  input  logic [PA_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam logic [DATA_W-1:0] RST_WORD = INVERT ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

  logic [DATA_W-1:0] stored_w;
  logic [DATA_W-1:0] word_arr [NUM_VARS];

  generate
    if (INVERT) begin : g_inv
      assign stored_w = ~wr_word;
    end else begin : g_true
      assign stored_w = wr_word;
    end
  endgenerate

  for (genvar e = 0; e < NUM_VARS; e++) begin : g_entry
    localparam logic [PA_W-1:0] MY_PA = PA_W'((REGION << IDX_W) + e);
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;
    logic              word_ld;

    always_comb begin
      word_ld = 1'b0;
      word_d  = word_q;
      if (fill_en) begin
        word_ld = 1'b1;
        word_d  = fill_word;
      end else if (wr_en && wr_addr == MY_PA) begin
        word_ld = 1'b1;
        word_d  = stored_w;
      end else if (inj_en && inj_addr == MY_PA) begin
        word_ld = 1'b1;
        word_d  = word_q ^ inj_mask;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= RST_WORD;
      end else if (word_ld) begin
        word_q <= word_d;
      end
    end

    assign word_arr[e] = word_q;
  end

  assign rd_word = (rd_addr[PA_W-1] == 1'(REGION)) ? word_arr[rd_addr[IDX_W-1:0]]
                                                     : {DATA_W{1'b0}};
endmodule

// File: rtl/mirror_compare.sv
module mirror_compare #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] true_word,
  input  logic [DATA_W-1:0] inv_word,
  output logic              mismatch
);
  logic [DATA_W-1:0] diff_bits;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign diff_bits[b] = true_word[b] ^ inv_word[b];
  end

  assign mismatch = ~(&diff_bits);
endmodule

// File: rtl/mirror_store.sv
module mirror_store #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_VARS = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_VARS),
  localparam int unsigned PA_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_corrupt,
  output logic              err_sticky,
  input  logic              err_clr,
  output logic              recover_req,
  input  logic              inj_en,
  input  logic              inj_bank,
  input  logic [IDX_W-1:0]  inj_idx,
  input  logic [DATA_W-1:0] inj_mask,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_val
);
  import mirror_pkg::*;

  logic              rst_sync_n;
  logic [PA_W-1:0]   wr_pa_a, wr_pa_b, rd_pa_a, rd_pa_b, inj_pa;
  logic [DATA_W-1:0] word_a, word_b;
  logic              mismatch;

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic              data_ld;
  logic              corrupt_d, corrupt_q;
  logic              sticky_d, sticky_q;
  logic              recover_d, recover_q;

  mirror_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_pa_a = {BANK_TRUE, wr_idx};
  assign wr_pa_b = {BANK_INV,  wr_idx};
  assign rd_pa_a = {BANK_TRUE, rd_idx};
  assign rd_pa_b = {BANK_INV,  rd_idx};
  assign inj_pa  = {inj_bank,  inj_idx};

  mirror_bank #(.DATA_W(DATA_W), .NUM_VARS(NUM_VARS), .REGION(0), .INVERT(1'b0)) u_bank_a (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_pa_a), .wr_word(wr_data),
    .inj_en(inj_en), .inj_addr(inj_pa), .inj_mask(inj_mask),
    .fill_en(fill_en), .fill_word(fill_val),
    .rd_addr(rd_pa_a), .rd_word(word_a)
  );

  mirror_bank #(.DATA_W(DATA_W), .NUM_VARS(NUM_VARS), .REGION(1), .INVERT(1'b1)) u_bank_b (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_pa_b), .wr_word(wr_data),
    .inj_en(inj_en), .inj_addr(inj_pa), .inj_mask(inj_mask),
    .fill_en(fill_en), .fill_word(fill_val),
    .rd_addr(rd_pa_b), .rd_word(word_b)
  );

  mirror_compare #(.DATA_W(DATA_W)) u_cmp (
    .true_word (word_a),
    .inv_word  (word_b),
    .mismatch  (mismatch)
  );

  // Next-state logic for the read result and error reporting.
  always_comb begin
    valid_d   = rd_en;
    data_ld   = rd_en;
    data_d    = word_a;
    corrupt_d = rd_en && mismatch;
    recover_d = rd_en && mismatch && !sticky_q;
    sticky_d  = sticky_q;
    if (rd_en && mismatch) begin
      sticky_d = 1'b1;
    end else if (err_clr) begin
      sticky_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q   <= 1'b0;
      corrupt_q <= 1'b0;
      sticky_q  <= 1'b0;
      recover_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      corrupt_q <= corrupt_d;
      sticky_q  <= sticky_d;
      recover_q <= recover_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q <= {DATA_W{1'b0}};
    end else if (data_ld) begin
      data_q <= data_d;
    end
  end

  assign rd_valid    = valid_q;
  assign rd_data     = data_q;
  assign rd_corrupt  = corrupt_q;
  assign err_sticky  = sticky_q;
  assign recover_req = recover_q;
endmodule

// File: rtl/mirror_store_sva.sv
module mirror_store_sva (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic rd_valid,
  input logic rd_corrupt,
  input logic err_sticky,
  input logic err_clr,
  input logic recover_req
);
  // R1: a result appears exactly one cycle after each read request
  p_valid_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_valid_only_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R3: a corruption flag belongs to a valid result
  p_corrupt_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_corrupt |-> rd_valid);
  // R6: detection latches, and the latch holds until cleared
  p_sticky_on_detect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_corrupt) |-> err_sticky);
  p_sticky_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);
  p_sticky_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> rd_corrupt);
  // R7: recovery request is a single pulse raised by a first detection
  p_recover_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recover_req |=> !recover_req);
  p_recover_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recover_req |-> (rd_corrupt && !$past(err_sticky)));
endmodule

bind mirror_store mirror_store_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .rd_en       (rd_en),
  .rd_valid    (rd_valid),
  .rd_corrupt  (rd_corrupt),
  .err_sticky  (err_sticky),
  .err_clr     (err_clr),
  .recover_req (recover_req)
);

// File: tb/mirror_store_bench.sv
`timescale 1ns/1ps
module mirror_store_bench;
  localparam int DW = 16;
  localparam int NV = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en, err_clr, inj_en, inj_bank, fill_en;
  logic [IW-1:0] wr_idx, rd_idx, inj_idx;
  logic [DW-1:0] wr_data, inj_mask, fill_val;
  logic          rd_valid, rd_corrupt, err_sticky, recover_req;
  logic [DW-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [DW-1:0] model [NV];

  // Stimulus table: {index, value}; later entries overwrite earlier ones.
  localparam logic [IW+DW-1:0] VEC [12] = '{
    {3'd0, 16'h1234}, {3'd1, 16'hFFFF}, {3'd2, 16'h0000}, {3'd3, 16'hA5A5},
    {3'd4, 16'h5A5A}, {3'd5, 16'h8001}, {3'd6, 16'h7FFE}, {3'd7, 16'h0F0F},
    {3'd2, 16'hC3C3}, {3'd0, 16'hBEEF}, {3'd7, 16'h0001}, {3'd5, 16'h4321}
  };

  always #2 clk = ~clk;

  mirror_store #(.DATA_W(DW), .NUM_VARS(NV)) u_mirror_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_corrupt(rd_corrupt),
    .err_sticky(err_sticky), .err_clr(err_clr), .recover_req(recover_req),
    .inj_en(inj_en), .inj_bank(inj_bank), .inj_idx(inj_idx), .inj_mask(inj_mask),
    .fill_en(fill_en), .fill_val(fill_val)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [IW-1:0] idx, input logic [DW-1:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    model[idx] = val;
  endtask

  task automatic do_read(input logic [IW-1:0] idx);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_inject(input logic bank, input logic [IW-1:0] idx,
                           input logic [DW-1:0] mask);
    @(negedge clk);
    inj_en = 1'b1; inj_bank = bank; inj_idx = idx; inj_mask = mask;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic read_clean(input logic [IW-1:0] idx, input string req);
    do_read(idx);
    check(rd_valid == 1'b1, req, 32'(rd_valid), 32'd1);
    check(rd_data == model[idx] && !rd_corrupt, req, {15'd0, rd_corrupt, rd_data},
          {16'd0, model[idx]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; err_clr = 1'b0; inj_en = 1'b0; fill_en = 1'b0;
    inj_bank = 1'b0; wr_idx = '0; rd_idx = '0; inj_idx = '0;
    wr_data = '0; inj_mask = '0; fill_val = '0;
    for (int i = 0; i < NV; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    check(!rd_valid && !err_sticky && !recover_req, "R2",
          {29'd0, rd_valid, err_sticky, recover_req}, 32'd0);
    for (int i = 0; i < NV; i++) read_clean(IW'(i), "R2");

    // R1: table of writes, then read every index
    for (int v = 0; v < 12; v++) do_write(VEC[v][IW+DW-1:DW], VEC[v][DW-1:0]);
    for (int i = 0; i < NV; i++) read_clean(IW'(i), "R1");
    @(negedge clk);
    check(rd_valid == 1'b0, "R1", 32'(rd_valid), 32'd0);

    // R10: read and write to the same index in the same cycle
    @(negedge clk);
    rd_en = 1'b1; rd_idx = 3'd3; wr_en = 1'b1; wr_idx = 3'd3; wr_data = 16'h1357;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(rd_data == 16'hA5A5, "R10", 32'(rd_data), 32'h0000A5A5);
    model[3] = 16'h1357;
    read_clean(3'd3, "R10");

    // R3/R7/R6: single flip in bank A
    do_inject(1'b0, 3'd2, 16'h0020);
    do_read(3'd2);
    check(rd_corrupt == 1'b1, "R3", 32'(rd_corrupt), 32'd1);
    check(recover_req == 1'b1, "R7", 32'(recover_req), 32'd1);
    check(err_sticky == 1'b1, "R6", 32'(err_sticky), 32'd1);
    @(negedge clk);
    check(recover_req == 1'b0, "R7", 32'(recover_req), 32'd0);
    // R9: neighbours unaffected
    read_clean(3'd1, "R9");
    read_clean(3'd3, "R9");
    check(err_sticky == 1'b1, "R6", 32'(err_sticky), 32'd1);
    do_clear();
    check(err_sticky == 1'b0, "R6", 32'(err_sticky), 32'd0);
    // R8: rewrite restores clean reads
    do_write(3'd2, 16'h2468);
    read_clean(3'd2, "R8");

    // R3/R7: single flip in bank B, then a repeat detection gives no pulse
    do_inject(1'b1, 3'd4, 16'h0001);
    do_read(3'd4);
    check(rd_corrupt == 1'b1, "R3", 32'(rd_corrupt), 32'd1);
    check(recover_req == 1'b1, "R7", 32'(recover_req), 32'd1);
    read_clean(3'd5, "R9");
    do_read(3'd4);
    check(rd_corrupt == 1'b1 && recover_req == 1'b0, "R7",
          {30'd0, rd_corrupt, recover_req}, 32'd2);

    // R6: set wins over clear in the same cycle
    @(negedge clk);
    rd_en = 1'b1; rd_idx = 3'd4; err_clr = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; err_clr = 1'b0;
    check(err_sticky == 1'b1, "R6", 32'(err_sticky), 32'd1);
    do_write(3'd4, 16'h5A5A);
    do_clear();

    // R5: same-position flip in both copies escapes detection
    do_inject(1'b0, 3'd5, 16'h0100);
    do_inject(1'b1, 3'd5, 16'h0100);
    do_read(3'd5);
    check(rd_corrupt == 1'b0, "R5", 32'(rd_corrupt), 32'd0);
    check(rd_data == (model[5] ^ 16'h0100), "R5", 32'(rd_data), 32'(model[5] ^ 16'h0100));
    check(err_sticky == 1'b0, "R5", 32'(err_sticky), 32'd0);

    // R4: stuck fills of both banks
    for (int f = 0; f < 3; f++) begin
      @(negedge clk);
      fill_en = 1'b1;
      fill_val = (f == 0) ? 16'h0000 : (f == 1) ? 16'hFFFF : 16'h3C96;
      @(negedge clk);
      fill_en = 1'b0;
      for (int i = 0; i < NV; i++) begin
        do_read(IW'(i));
        check(rd_corrupt == 1'b1, "R4", 32'(rd_corrupt), 32'd1);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule